// File: doc/BRIEF.md
# Vector Bitwise Logic Unit

This block performs bitwise logic on 128-bit vector operands. A request carries an opcode, an accumulator operand `acc_d`, two source operands `src_n` and `src_m`, a flag that narrows the operation to the low 64 bits, and, for the two immediate forms, a 32-bit immediate with a lane-size select. The unit computes the selected function, clears the upper half in narrow mode, and registers the result. `res_valid` follows `req_valid` by exactly one clock.

Three of the operations merge bits from the sources into the old accumulator value. One picks per bit between `src_n` and `src_m` under control of `acc_d`. The other two insert `src_n` bits into `acc_d` where `src_m` is set, or where it is clear. The immediate forms copy the immediate into every 16-bit or 32-bit lane and then combine that pattern with `acc_d`. An undefined opcode, or an immediate form with an unsupported lane size, raises `res_err` and yields a zero result.

Top module: `vec_bitlogic`

## Requirements
- R1: Opcode 0 gives src_n AND src_m, opcode 2 gives src_n OR src_m, and opcode 4 gives src_n XOR src_m.
- R2: Opcode 1 (clear) gives src_n AND NOT src_m, and opcode 3 gives src_n OR NOT src_m.
- R3: Opcode 5 gives NOT src_n. src_m and acc_d have no effect on it.
- R4: Opcode 6 (select) takes each result bit from src_n where acc_d is 1 and from src_m where acc_d is 0.
- R5: Opcode 7 (insert-if-set) takes src_n where src_m is 1 and keeps acc_d where src_m is 0.
- R6: Opcode 8 (insert-if-clear) takes src_n where src_m is 0 and keeps acc_d where src_m is 1.
- R7: Opcode 9 gives acc_d AND NOT pattern, and opcode 10 gives acc_d OR pattern. The pattern is imm[15:0] copied into eight 16-bit lanes when lane_sz=1, or imm[31:0] copied into four 32-bit lanes when lane_sz=2.
- R8: For opcodes 9 and 10, lane_sz values 0 and 3 raise res_err with a zero result. For every other opcode, lane_sz and imm have no effect.
- R9: Opcodes 11 to 15 raise res_err with a zero result. Every legal request clears res_err.
- R10: When narrow=1, result bits 127:64 are zero for every opcode, and bits 63:0 are unchanged.
- R11: res_valid equals req_valid delayed by one clock. result and res_err change only in the cycle after an accepted request and hold otherwise.
- R12: After reset, res_valid, res_err and result are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe |
| opcode | input | 4 | Operation select |
| narrow | input | 1 | 1: 64-bit operation, upper half zeroed |
| lane_sz | input | 2 | Immediate lane size: 1 = 16-bit, 2 = 32-bit |
| imm | input | 32 | Immediate value |
| acc_d | input | 128 | Old accumulator value |
| src_n | input | 128 | First source |
| src_m | input | 128 | Second source |
| res_valid | output | 1 | Result strobe |
| result | output | 128 | Registered result |
| res_err | output | 1 | Illegal opcode or lane size |

## Verification
The assertions check a set of properties on every cycle. The valid delay and the holding of the result are checked. So are the zeroed upper half in narrow mode and the zero result under an error. On accepted requests they also check the per-bit selection rules of the three merge operations. Only the bench scenarios show the exact values of the plain logic functions, the immediate replication at each lane size, and the error flag for each bad opcode and lane size. The bench also shows that ignored inputs really do have no effect.

// File: rtl/vbl_pkg.sv
package vbl_pkg;
  typedef enum logic [3:0] {
    OP_AND   = 4'd0,
    OP_CLR   = 4'd1,
    OP_OR    = 4'd2,
    OP_ORN   = 4'd3,
    OP_XOR   = 4'd4,
    OP_NOT   = 4'd5,
    OP_SEL   = 4'd6,
    OP_INST  = 4'd7,
    OP_INSF  = 4'd8,
    OP_ICLR  = 4'd9,
    OP_IOR   = 4'd10
  } vbl_op_e;

  localparam logic [1:0] LANE16 = 2'd1;
  localparam logic [1:0] LANE32 = 2'd2;

  function automatic logic op_known(input logic [3:0] op);
    return op <= OP_IOR;
  endfunction

  function automatic logic op_uses_imm(input logic [3:0] op);
    return (op == OP_ICLR) || (op == OP_IOR);
  endfunction

  // merge a into b where the mask bit is set
  function automatic logic [127:0] merge_bits(input logic [127:0] keep,
                                              input logic [127:0] take,
                                              input logic [127:0] mask);
    return keep ^ ((take ^ keep) & mask);
  endfunction
endpackage

// File: rtl/vbl_imm_rep.sv
module vbl_imm_rep #(
  parameter int VEC_W = 128,
  parameter int IMM_W = 32
) (
  input  logic [IMM_W-1:0] imm,
  input  logic [1:0]       lane_sz,
  output logic [VEC_W-1:0] pattern,
  output logic             lane_ok
);
  localparam int H_W    = IMM_W / 2;
  localparam int N16    = VEC_W / H_W;
  localparam int N32    = VEC_W / IMM_W;

  logic [VEC_W-1:0] rep16;
  logic [VEC_W-1:0] rep32;

  for (genvar g = 0; g < N16; g++) begin : g_l16
    assign rep16[g*H_W +: H_W] = imm[H_W-1:0];
  end
  for (genvar g = 0; g < N32; g++) begin : g_l32
    assign rep32[g*IMM_W +: IMM_W] = imm;
  end

  always_comb begin
    lane_ok = 1'b1;
    case (lane_sz)
      vbl_pkg::LANE16: pattern = rep16;
      vbl_pkg::LANE32: pattern = rep32;
      default: begin
        pattern = '0;
        lane_ok = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/vbl_core.sv
module vbl_core #(
  parameter int VEC_W = 128
) (
  input  logic [3:0]       opcode,
  input  logic [VEC_W-1:0] acc_d,
  input  logic [VEC_W-1:0] src_n,
  input  logic [VEC_W-1:0] src_m,
  input  logic [VEC_W-1:0] pattern,
  input  logic             lane_ok,
  output logic [VEC_W-1:0] value,
  output logic             bad
);
  import vbl_pkg::*;

  always_comb begin
    bad   = 1'b0;
    value = '0;
    case (opcode)
      OP_AND:  value = src_n & src_m;
      OP_CLR:  value = src_n & ~src_m;
      OP_OR:   value = src_n | src_m;
      OP_ORN:  value = src_n | ~src_m;
      OP_XOR:  value = src_n ^ src_m;
      OP_NOT:  value = ~src_n;
      OP_SEL:  value = ((src_n ^ src_m) & acc_d) ^ src_m;
      OP_INST: value = merge_bits(acc_d, src_n, src_m);
      OP_INSF: value = merge_bits(acc_d, src_n, ~src_m);
      OP_ICLR: begin
        bad   = !lane_ok;
        value = lane_ok ? (acc_d & ~pattern) : '0;
      end
      OP_IOR: begin
        bad   = !lane_ok;
        value = lane_ok ? (acc_d | pattern) : '0;
      end
      default: bad = 1'b1;
    endcase
  end
endmodule

// File: rtl/vec_bitlogic.sv
module vec_bitlogic #(
  parameter int VEC_W = 128,
  parameter int IMM_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [3:0]       opcode,
  input  logic             narrow,
  input  logic [1:0]       lane_sz,
  input  logic [IMM_W-1:0] imm,
  input  logic [VEC_W-1:0] acc_d,
  input  logic [VEC_W-1:0] src_n,
  input  logic [VEC_W-1:0] src_m,
  output logic             res_valid,
  output logic [VEC_W-1:0] result,
  output logic             res_err
);
  import vbl_pkg::*;

  localparam int HALF = VEC_W / 2;

  logic [VEC_W-1:0] pattern;
  logic             lane_ok;
  logic [VEC_W-1:0] core_val;
  logic             core_bad;
  logic [VEC_W-1:0] shaped;

  vbl_imm_rep #(.VEC_W(VEC_W), .IMM_W(IMM_W)) u_rep (
    .imm(imm), .lane_sz(lane_sz), .pattern(pattern), .lane_ok(lane_ok)
  );

  vbl_core #(.VEC_W(VEC_W)) u_core (
    .opcode(opcode), .acc_d(acc_d), .src_n(src_n), .src_m(src_m),
    .pattern(pattern), .lane_ok(lane_ok), .value(core_val), .bad(core_bad)
  );

  assign shaped = narrow ? {{HALF{1'b0}}, core_val[HALF-1:0]} : core_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      result    <= '0;
      res_err   <= 1'b0;
    end else begin
      res_valid <= req_valid;
      if (req_valid) begin
        result  <= shaped;
        res_err <= core_bad;
      end
    end
  end

  a_r11_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> res_valid);
  a_r11_valid_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !res_valid);
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> ($stable(result) && $stable(res_err)));
  a_r10_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && narrow) |=> (result[VEC_W-1:HALF] == '0));
  a_r9_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
    res_err |-> (result == '0));
  a_r4_sel_rule: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && opcode == OP_SEL) |->
      ((((core_val ^ src_n) & acc_d) | ((core_val ^ src_m) & ~acc_d)) == '0));
  a_r5_ins_set: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && opcode == OP_INST) |->
      ((((core_val ^ src_n) & src_m) | ((core_val ^ acc_d) & ~src_m)) == '0));
  a_r6_ins_clr: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && opcode == OP_INSF) |->
      ((((core_val ^ src_n) & ~src_m) | ((core_val ^ acc_d) & src_m)) == '0));
endmodule

// File: tb/vec_bitlogic_bench.sv
module vec_bitlogic_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic [3:0]   opcode = '0;
  logic         narrow = 1'b0;
  logic [1:0]   lane_sz = '0;
  logic [31:0]  imm = '0;
  logic [127:0] acc_d = '0, src_n = '0, src_m = '0;
  logic         res_valid, res_err;
  logic [127:0] result;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  vec_bitlogic u_vec_bitlogic (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .opcode(opcode),
    .narrow(narrow), .lane_sz(lane_sz), .imm(imm), .acc_d(acc_d),
    .src_n(src_n), .src_m(src_m), .res_valid(res_valid), .result(result),
    .res_err(res_err)
  );

  // expected {err, value}, bit by bit
  function automatic logic [128:0] model(input logic [3:0] op, input logic nw,
      input logic [1:0] ls, input logic [31:0] im, input logic [127:0] d,
      input logic [127:0] n, input logic [127:0] m);
    logic [127:0] v;
    logic e;
    logic p;
    e = 1'b0;
    v = '0;
    if (op > 4'd10) e = 1'b1;
    if ((op == 4'd9 || op == 4'd10) && !(ls == 2'd1 || ls == 2'd2)) e = 1'b1;
    for (int i = 0; i < 128; i++) begin
      p = (ls == 2'd1) ? im[i % 16] : im[i % 32];
      case (op)
        4'd0:  v[i] = n[i] && m[i];
        4'd1:  v[i] = n[i] && !m[i];
        4'd2:  v[i] = n[i] || m[i];
        4'd3:  v[i] = n[i] || !m[i];
        4'd4:  v[i] = n[i] != m[i];
        4'd5:  v[i] = !n[i];
        4'd6:  v[i] = d[i] ? n[i] : m[i];
        4'd7:  v[i] = m[i] ? n[i] : d[i];
        4'd8:  v[i] = m[i] ? d[i] : n[i];
        4'd9:  v[i] = d[i] && !p;
        4'd10: v[i] = d[i] || p;
        default: v[i] = 1'b0;
      endcase
      if (e || (nw && i >= 64)) v[i] = 1'b0;
    end
    return {e, v};
  endfunction

  task automatic check(input string req, input logic [128:0] act, input logic [128:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(input string req, input logic [3:0] op, input logic nw,
      input logic [1:0] ls, input logic [31:0] im, input logic [127:0] d,
      input logic [127:0] n, input logic [127:0] m);
    @(negedge clk);
    req_valid = 1'b1; opcode = op; narrow = nw; lane_sz = ls; imm = im;
    acc_d = d; src_n = n; src_m = m;
    @(negedge clk);
    req_valid = 1'b0;
    check({req, " valid"}, {128'd0, res_valid}, {128'd0, 1'b1});
    check(req, {res_err, result}, model(op, nw, ls, im, d, n, m));
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom(), $urandom(), $urandom(), $urandom()};
  endfunction

  initial begin
    int unused;
    logic [128:0] held;
    logic [127:0] a, b, c;
    unused = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    check("R12 reset", {res_valid, res_err, result}, 130'd0);
    rst_n = 1'b1;
    a = 128'hF0F0_1234_5678_9ABC_DEF0_0F0F_AAAA_5555;
    b = 128'h0FF0_FFFF_0000_1111_2222_3333_CCCC_3C3C;
    c = 128'hFFFF_0000_FFFF_0000_00FF_FF00_0F0F_F0F0;
    run("R1 and", 4'd0, 0, 0, 0, c, a, b);
    run("R1 or", 4'd2, 0, 0, 0, c, a, b);
    run("R1 xor", 4'd4, 0, 0, 0, c, a, b);
    run("R2 clear", 4'd1, 0, 0, 0, c, a, b);
    run("R2 orn", 4'd3, 0, 0, 0, c, a, b);
    run("R3 not", 4'd5, 0, 0, 0, c, a, b);
    run("R3 not ignores m d", 4'd5, 0, 0, 0, ~c, a, ~b);
    run("R4 select", 4'd6, 0, 0, 0, c, a, b);
    run("R5 insert set", 4'd7, 0, 0, 0, c, a, b);
    run("R6 insert clear", 4'd8, 0, 0, 0, c, a, b);
    run("R7 imm clr 16", 4'd9, 0, 2'd1, 32'hDEAD_00FF, c, a, b);
    run("R7 imm or 32", 4'd10, 0, 2'd2, 32'h8000_0001, c, a, b);
    run("R7 imm or 16", 4'd10, 0, 2'd1, 32'h1234_8001, '0, a, b);
    run("R8 lane 0", 4'd9, 0, 2'd0, 32'hFFFF_FFFF, c, a, b);
    run("R8 lane 3", 4'd10, 0, 2'd3, 32'hFFFF_FFFF, c, a, b);
    run("R8 lane ignored", 4'd4, 0, 2'd3, 32'h5555_AAAA, c, a, b);
    run("R9 op 11", 4'd11, 0, 2'd1, 0, c, a, b);
    run("R9 op 15", 4'd15, 1, 2'd2, 0, c, a, b);
    run("R9 err clears", 4'd0, 0, 0, 0, c, a, b);
    run("R10 narrow not", 4'd5, 1, 0, 0, c, '0, b);
    run("R10 narrow imm", 4'd10, 1, 2'd2, 32'hFFFF_FFFF, c, a, b);
    // R11 hold: change inputs without a request
    held = {res_err, result};
    @(negedge clk);
    opcode = 4'd5; src_n = ~a; acc_d = ~c;
    @(negedge clk);
    check("R11 no valid", {128'd0, res_valid}, 129'd0);
    check("R11 hold", {res_err, result}, held);
    for (int k = 0; k < 400; k++) begin
      logic [3:0] op;
      op = 4'($urandom_range(0, 15));
      run("R1-R10 random", op, 1'($urandom()), 2'($urandom()), $urandom(),
          rnd128(), rnd128(), rnd128());
    end
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule